// File: doc/BRIEF.md
# Tiered Address Window Select Decoder

This block turns the 16-bit address of an 8-bit microcontroller into a single memory or peripheral select. It holds sixteen programmable address windows: eight for sectors of the large (main) flash array, four for sectors of the small (secondary) flash array, one for the on-chip SRAM, one for the block of I/O control registers, and two for external peripherals. Each window is an inclusive start and end address plus an enable bit. Windows are loaded through a small write port, and a write takes effect on the following clock cycle.

Windows are allowed to overlap across tiers, and the higher tier wins without any error. The SRAM, I/O-control and peripheral windows form the top tier. Secondary flash is the middle tier and main flash is the lowest. Overlap inside a tier is a configuration fault. For the two flash tiers, a flag is raised continuously from the window registers, and it stays raised until the windows are corrected. For the top tier, an access that hits two or more of its windows drives no select and raises a contention flag instead. A flash window that is larger than the physical sector of its array is rejected: it never matches, and it raises a size-error flag.

The decode result is registered on each clock edge that has the address-valid strobe high. It is held on all other edges.

Top module: `csd_decoder`

## Requirements
- R1: A synchronous reset clears `sel`, `none`, `hi_clash`, `main_ovl`, `sec_ovl` and `size_err` to 0. It also clears every window to start 0000h, end 0000h, disabled.
- R2: A window matches an address when it is enabled and start <= address <= end. A disabled window, or a window with end < start, never matches. If no accepted window matches, `none` is 1 and `sel` is 0.
- R3: When a secondary-flash window and a main-flash window both match, only the secondary-flash select is driven.
- R4: When exactly one top-tier window (SRAM, I/O control, peripheral) matches, only its select is driven, whichever flash windows also match.
- R5: When two or more top-tier windows match, `hi_clash` is 1, `sel` is 0 and `none` is 0.
- R6: `main_ovl` is 1 whenever two accepted main-flash windows share at least one address. It returns to 0 once the windows no longer overlap. It follows a window write by two clock edges.
- R7: `sec_ovl` behaves the same way as `main_ovl`, but for the accepted secondary-flash windows.
- R8: A flash window is accepted only if it is enabled, has start <= end, and spans (end-start+1) no more than MAIN_LIMIT (16384) bytes for main flash or SEC_LIMIT (8192) bytes for secondary flash. An enabled, ordered window that spans more than its limit never matches and sets `size_err`.
- R9: `sel`, `none` and `hi_clash` update only on clock edges where `addr_vld` is 1, and they hold their values otherwise.
- R10: At most one bit of `sel` is 1, and `none` is never 1 together with a `sel` bit or with `hi_clash`.
- R11: The window index maps as follows: 0-7 are main flash, 8-11 are secondary flash, 12 is SRAM, 13 is I/O control, and 14-15 are peripherals. `sel` bit i is the select for window i. `cfg_fld` 0 writes the start address, 1 writes the end address, and 2 writes the enable from `cfg_data[0]`. Field 3 is ignored.
- R12: If overlapping windows of one flash tier both match, the lowest-indexed one of that tier is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Bus address |
| addr_vld | input | 1 | Address-valid strobe; the decode is captured when high |
| cfg_we | input | 1 | Window register write enable |
| cfg_idx | input | 4 | Window index |
| cfg_fld | input | 2 | Field selector: 0 start, 1 end, 2 enable |
| cfg_data | input | 16 | Write value |
| sel | output | 16 | One-hot registered select, bit i = window i |
| none | output | 1 | No accepted window matched the last captured address |
| hi_clash | output | 1 | Top-tier contention on the last captured address |
| main_ovl | output | 1 | Main-flash windows overlap |
| sec_ovl | output | 1 | Secondary-flash windows overlap |
| size_err | output | 1 | A flash window exceeds its sector size |

## Verification
The hardest case to reach from the ports is an address that falls in three layers at once while one of those layers is itself faulty. Examples are a flash window that is oversized and must drop out so that the lower tier shows through, or an overlapping pair in one tier sitting under a top-tier window. Directed sequences build exactly these stacks around 8000h-C0FFh, then grow and shrink single windows and check both the access result and the flags.

Randomly generated configurations then reload all sixteen windows. Their start addresses are packed into a narrow upper region so that tiers overlap often. The addresses probed are mostly window edges and the addresses just outside them.

// File: rtl/csd_pkg.sv
package csd_pkg;

    localparam int ADDR_W    = 16;
    localparam int N_MAIN    = 8;
    localparam int N_SEC     = 4;
    localparam int N_PERI    = 2;
    localparam int N_HI      = 2 + N_PERI;
    localparam int N_WIN     = N_MAIN + N_SEC + N_HI;
    localparam int IDX_W     = $clog2(N_WIN);
    localparam int SEC_BASE  = N_MAIN;
    localparam int SRAM_IDX  = N_MAIN + N_SEC;
    localparam int IOC_IDX   = SRAM_IDX + 1;
    localparam int PERI_BASE = IOC_IDX + 1;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } win_t;

    typedef enum logic [1:0] {
        FLD_LO  = 2'd0,
        FLD_HI  = 2'd1,
        FLD_EN  = 2'd2,
        FLD_RSV = 2'd3
    } fld_e;

    typedef enum logic [2:0] {
        RES_NONE,
        RES_HI,
        RES_SEC,
        RES_MAIN,
        RES_CLASH
    } res_e;

endpackage

// File: rtl/csd_cfg_regs.sv
module csd_cfg_regs
    import csd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [IDX_W-1:0]       idx,
    input  logic [1:0]             fld,
    input  logic [ADDR_W-1:0]      data,
    output win_t [N_WIN-1:0]       win
);

    win_t [N_WIN-1:0] win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else if (we && (int'(idx) < N_WIN)) begin
            unique case (fld_e'(fld))
                FLD_LO:  win_q[idx].lo <= data;
                FLD_HI:  win_q[idx].hi <= data;
                FLD_EN:  win_q[idx].en <= data[0];
                FLD_RSV: ;
            endcase
        end
    end

    assign win = win_q;

endmodule

// File: rtl/csd_window_match.sv
module csd_window_match
    import csd_pkg::*;
#(
    parameter int LIMIT      = 16384,
    parameter bit CHECK_SIZE = 1'b1
) (
    input  win_t              w,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              qual,
    output logic              oversize
);

    localparam logic [ADDR_W:0] LIM_V = LIMIT[ADDR_W:0];

    logic            ordered;
    logic [ADDR_W:0] span;

    always_comb begin
        ordered  = (w.lo <= w.hi);
        span     = {1'b0, w.hi} - {1'b0, w.lo} + {{ADDR_W{1'b0}}, 1'b1};
        oversize = CHECK_SIZE && w.en && ordered && (span > LIM_V);
        qual     = w.en && ordered && !oversize;
        hit      = qual && (addr >= w.lo) && (addr <= w.hi);
    end

endmodule

// File: rtl/csd_overlap_chk.sv
module csd_overlap_chk
    import csd_pkg::*;
#(
    parameter int N = 4
) (
    input  win_t [N-1:0] w,
    input  logic [N-1:0] qual,
    output logic         clash
);

    always_comb begin
        clash = 1'b0;
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                if (qual[i] && qual[j] &&
                    (w[i].lo <= w[j].hi) && (w[j].lo <= w[i].hi)) begin
                    clash = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/csd_decoder.sv
module csd_decoder
    import csd_pkg::*;
#(
    parameter int MAIN_LIMIT = 16384,
    parameter int SEC_LIMIT  = 8192
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               addr_vld,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [1:0]         cfg_fld,
    input  logic [ADDR_W-1:0]  cfg_data,
    output logic [N_WIN-1:0]   sel,
    output logic               none,
    output logic               hi_clash,
    output logic               main_ovl,
    output logic               sec_ovl,
    output logic               size_err
);

    win_t [N_WIN-1:0] win;
    logic [N_WIN-1:0] hits;
    logic [N_WIN-1:0] qual;
    logic [N_WIN-1:0] oversize;

    logic [N_MAIN-1:0] main_hits;
    logic [N_SEC-1:0]  sec_hits;
    logic [N_HI-1:0]   hi_hits;
    logic              main_clash_c;
    logic              sec_clash_c;

    res_e              res;
    logic [N_WIN-1:0]  sel_d;

    logic [N_WIN-1:0]  sel_q;
    logic              none_q;
    logic              clash_q;
    logic              main_ovl_q;
    logic              sec_ovl_q;
    logic              size_q;

    csd_cfg_regs u_cfg (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .idx  (cfg_idx),
        .fld  (cfg_fld),
        .data (cfg_data),
        .win  (win)
    );

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        localparam int LIM = (g < N_MAIN) ? MAIN_LIMIT : SEC_LIMIT;
        localparam bit CHK = (g < SRAM_IDX);
        csd_window_match #(
            .LIMIT      (LIM),
            .CHECK_SIZE (CHK)
        ) u_match (
            .w        (win[g]),
            .addr     (addr),
            .hit      (hits[g]),
            .qual     (qual[g]),
            .oversize (oversize[g])
        );
    end

    csd_overlap_chk #(.N(N_MAIN)) u_main_ovl (
        .w     (win[N_MAIN-1:0]),
        .qual  (qual[N_MAIN-1:0]),
        .clash (main_clash_c)
    );

    csd_overlap_chk #(.N(N_SEC)) u_sec_ovl (
        .w     (win[SRAM_IDX-1:SEC_BASE]),
        .qual  (qual[SRAM_IDX-1:SEC_BASE]),
        .clash (sec_clash_c)
    );

    assign main_hits = hits[N_MAIN-1:0];
    assign sec_hits  = hits[SRAM_IDX-1:SEC_BASE];
    assign hi_hits   = hits[N_WIN-1:SRAM_IDX];

    // tier resolution
    always_comb begin
        if ($countones(hi_hits) > 1)  res = RES_CLASH;
        else if (|hi_hits)            res = RES_HI;
        else if (|sec_hits)           res = RES_SEC;
        else if (|main_hits)          res = RES_MAIN;
        else                          res = RES_NONE;
    end

    // select vector for the winning tier
    always_comb begin
        sel_d = '0;
        unique case (res)
            RES_HI:    sel_d[N_WIN-1:SRAM_IDX]    = hi_hits;
            RES_SEC:   sel_d[SRAM_IDX-1:SEC_BASE] = sec_hits & (-sec_hits);
            RES_MAIN:  sel_d[N_MAIN-1:0]          = main_hits & (-main_hits);
            RES_CLASH: sel_d = '0;
            RES_NONE:  sel_d = '0;
            default:   sel_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q      <= '0;
            none_q     <= 1'b0;
            clash_q    <= 1'b0;
            main_ovl_q <= 1'b0;
            sec_ovl_q  <= 1'b0;
            size_q     <= 1'b0;
        end else begin
            if (addr_vld) begin
                sel_q   <= sel_d;
                none_q  <= (res == RES_NONE);
                clash_q <= (res == RES_CLASH);
            end
            main_ovl_q <= main_clash_c;
            sec_ovl_q  <= sec_clash_c;
            size_q     <= |oversize;
        end
    end

    assign sel      = sel_q;
    assign none     = none_q;
    assign hi_clash = clash_q;
    assign main_ovl = main_ovl_q;
    assign sec_ovl  = sec_ovl_q;
    assign size_err = size_q;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (sel_q == '0 && !none_q && !clash_q && !main_ovl_q && !sec_ovl_q && !size_q));

    p_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_q) && !(none_q && (|sel_q || clash_q)));

    p_clash_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        clash_q |-> (sel_q == '0 && !none_q));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !addr_vld |=> ($stable(sel_q) && $stable(none_q) && $stable(clash_q)));

    p_hi_over_flash_r4: assert property (@(posedge clk) disable iff (rst)
        (addr_vld && $countones(hi_hits) == 1) |=> (sel_q[SRAM_IDX-1:0] == '0));

endmodule

// File: tb/csd_decoder_tb.sv
module csd_decoder_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr;
    logic        addr_vld;
    logic        cfg_we;
    logic [3:0]  cfg_idx;
    logic [1:0]  cfg_fld;
    logic [15:0] cfg_data;
    logic [15:0] sel;
    logic        none, hi_clash, main_ovl, sec_ovl, size_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [15:0] m_lo [16];
    logic [15:0] m_hi [16];
    bit          m_en [16];

    always #4 clk = ~clk;

    csd_decoder u_dut (
        .clk(clk), .rst(rst), .addr(addr), .addr_vld(addr_vld),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_fld(cfg_fld), .cfg_data(cfg_data),
        .sel(sel), .none(none), .hi_clash(hi_clash),
        .main_ovl(main_ovl), .sec_ovl(sec_ovl), .size_err(size_err)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic bit m_over(int i);
        int span;
        if (!m_en[i] || m_lo[i] > m_hi[i]) return 0;
        span = int'(m_hi[i]) - int'(m_lo[i]) + 1;
        if (i < 8)  return span > 16384;
        if (i < 12) return span > 8192;
        return 0;
    endfunction

    function automatic bit m_ok(int i);
        return m_en[i] && (m_lo[i] <= m_hi[i]) && !m_over(i);
    endfunction

    function automatic bit m_hit(int i, logic [15:0] a);
        return m_ok(i) && a >= m_lo[i] && a <= m_hi[i];
    endfunction

    // returns {clash, none, sel}
    function automatic logic [17:0] m_decode(logic [15:0] a);
        int nh = 0;
        logic [15:0] s = '0;
        for (int i = 12; i < 16; i++) if (m_hit(i, a)) begin nh++; s[i] = 1'b1; end
        if (nh > 1) return {1'b1, 1'b0, 16'h0};
        if (nh == 1) return {1'b0, 1'b0, s};
        for (int i = 8; i < 12; i++) if (m_hit(i, a)) begin s[i] = 1'b1; return {2'b00, s}; end
        for (int i = 0; i < 8; i++)  if (m_hit(i, a)) begin s[i] = 1'b1; return {2'b00, s}; end
        return {1'b0, 1'b1, 16'h0};
    endfunction

    function automatic bit m_ovl(int b, int n);
        for (int i = b; i < b + n; i++)
            for (int j = i + 1; j < b + n; j++)
                if (m_ok(i) && m_ok(j) && m_lo[i] <= m_hi[j] && m_lo[j] <= m_hi[i]) return 1;
        return 0;
    endfunction

    function automatic bit m_size();
        for (int i = 0; i < 12; i++) if (m_over(i)) return 1;
        return 0;
    endfunction

    task automatic wr(int idx, int fld, logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx[3:0]; cfg_fld = fld[1:0]; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (fld)
            0: m_lo[idx] = d;
            1: m_hi[idx] = d;
            2: m_en[idx] = d[0];
            default: ;
        endcase
    endtask

    task automatic set_win(int idx, logic [15:0] lo, logic [15:0] hi, bit en);
        wr(idx, 0, lo);
        wr(idx, 1, hi);
        wr(idx, 2, {15'h0, en});
    endtask

    task automatic access(string req, logic [15:0] a);
        logic [17:0] e;
        @(negedge clk);
        addr = a; addr_vld = 1'b1;
        @(negedge clk);
        addr_vld = 1'b0;
        e = m_decode(a);
        chk(req, {14'h0, hi_clash, none, sel}, {14'h0, e});
    endtask

    task automatic flags(string req);
        @(negedge clk);
        chk(req, {29'h0, main_ovl, sec_ovl, size_err},
                 {29'h0, m_ovl(0, 8), m_ovl(8, 4), m_size()});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] keep;
        void'($urandom(32'd1234));
        rst = 1'b1; addr = '0; addr_vld = 0; cfg_we = 0; cfg_idx = 0; cfg_fld = 0; cfg_data = 0;
        for (int i = 0; i < 16; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_en[i] = 0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 outputs", {26'h0, sel, none, hi_clash, main_ovl, sec_ovl, size_err}, 32'h0);

        // R2 nothing enabled
        access("R2 all disabled", 16'h8000);
        chk("R2 none flag", {31'h0, none}, 32'h1);

        // layered example
        set_win(0, 16'h8000, 16'hBFFF, 1);
        set_win(8, 16'h8000, 16'h9FFF, 1);
        set_win(12, 16'h8000, 16'h87FF, 1);
        flags("R6 R7 R8 clean layered");
        access("R4 sram low edge", 16'h8000);
        chk("R4 sram bit12", {16'h0, sel}, 32'h1000);
        access("R4 sram high edge", 16'h87FF);
        access("R3 sec above sram", 16'h8800);
        chk("R3 sec bit8", {16'h0, sel}, 32'h0100);
        access("R3 sec top", 16'h9FFF);
        access("R2 main A000", 16'hA000);
        chk("R2 main bit0", {16'h0, sel}, 32'h0001);
        access("R2 main BFFF", 16'hBFFF);
        access("R2 above all", 16'hC000);
        access("R2 below all", 16'h7FFF);

        // R9 hold without strobe
        access("R9 setup", 16'h8800);
        keep = sel;
        @(negedge clk); addr = 16'h8000;
        @(negedge clk); @(negedge clk);
        chk("R9 held sel", {16'h0, sel}, {16'h0, keep});

        // R5 contention
        set_win(14, 16'h8000, 16'h80FF, 1);
        access("R5 clash", 16'h8010);
        chk("R5 clash flag", {31'h0, hi_clash}, 32'h1);
        access("R4 sram only", 16'h8100);
        // R11 enable field and reserved field
        wr(12, 2, 16'h0000);
        access("R11 enable write", 16'h8010);
        chk("R11 peri bit14", {16'h0, sel}, 32'h4000);
        wr(14, 3, 16'h0000);
        access("R11 reserved field ignored", 16'h8010);
        wr(12, 2, 16'h0001);
        wr(14, 2, 16'h0000);

        // R6 main overlap and R12 lowest index
        set_win(1, 16'hB000, 16'hC0FF, 1);
        flags("R6 overlap set");
        chk("R6 main_ovl", {31'h0, main_ovl}, 32'h1);
        access("R12 lowest main", 16'hB100);
        chk("R12 bit0", {16'h0, sel}, 32'h0001);
        access("R6 upper part main1", 16'hC050);
        wr(1, 0, 16'hC000);
        flags("R6 overlap cleared");

        // R7 secondary overlap
        set_win(9, 16'h9000, 16'h9100, 1);
        flags("R7 overlap set");
        chk("R7 sec_ovl", {31'h0, sec_ovl}, 32'h1);
        access("R12 lowest sec", 16'h9050);
        wr(9, 2, 16'h0000);
        flags("R7 overlap cleared");

        // R8 oversize secondary window rejected
        set_win(10, 16'hA000, 16'hC000, 1);
        flags("R8 size set");
        chk("R8 size_err", {31'h0, size_err}, 32'h1);
        access("R8 oversize rejected", 16'hB500);
        chk("R8 main shows", {16'h0, sel}, 32'h0001);
        wr(10, 1, 16'hBFFF);
        flags("R8 size cleared");
        access("R8 exact limit accepted", 16'hB500);
        chk("R8 sec bit10", {16'h0, sel}, 32'h0400);
        // main exactly at and above limit
        set_win(2, 16'h0000, 16'h3FFF, 1);
        access("R8 main at limit", 16'h1000);
        wr(2, 1, 16'h4000);
        flags("R8 main oversize");
        access("R8 main oversize rejected", 16'h1000);

        // random configurations
        for (int round = 0; round < 40; round++) begin
            for (int w = 0; w < 16; w++) begin
                logic [15:0] lo, hi;
                int len;
                lo  = 16'h6000 + 16'($urandom_range(0, 16'h5FFF));
                len = $urandom_range(0, 16'h4800);
                hi  = (int'(lo) + len > 16'hFFFF) ? 16'hFFFF : 16'(int'(lo) + len);
                if ($urandom_range(0, 15) == 0) hi = lo - 1;
                set_win(w, lo, hi, (w >= 12) ? ($urandom_range(0, 3) == 0) : $urandom_range(0, 1) == 1);
            end
            flags("R6 R7 R8 random flags");
            for (int k = 0; k < 24; k++) begin
                logic [15:0] a;
                int w;
                w = $urandom_range(0, 15);
                case ($urandom_range(0, 4))
                    0: a = m_lo[w];
                    1: a = m_hi[w];
                    2: a = m_lo[w] - 1;
                    3: a = m_hi[w] + 1;
                    default: a = 16'($urandom);
                endcase
                access("R2 R3 R4 R5 R10 R12 random", a);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule